// File: doc/BRIEF.md
# Byte-Lane Parity Checker and Regenerator

This block guards one 36-bit data port that is split into four 9-bit lanes, each lane carrying eight data bits and one parity bit in its top position. Toward storage, it checks the word on the incoming bus, lane by lane. The check follows a mode select that picks odd or even parity and skips any lane the bus-size logic marks as unused. The result is reported on an active-low error flag, with no register in the path.

Toward the reader, it loads an output register from the word that storage hands over. When regeneration is enabled, the block rebuilds each lane's top bit from that lane's lower eight bits, using the same odd/even select, before the word enters the register. The parity trees are shared between checking and regeneration. For that reason the error flag is held inactive while a mailbox read with regeneration is in progress. The word sent to storage always keeps all nine bits of every lane exactly as they arrived.

Top module: `parity_lane_guard`

## Requirements
- R1: Lane k occupies bits [9k+8:9k], for k = 0 to 3. Bit 9k+8 is that lane's parity bit, and bits [9k+7:9k] are its data bits.
- R2: With `odd_mode` = 1, a lane passes when its nine bits hold an odd number of ones. With `odd_mode` = 0, it passes when they hold an even number of ones.
- R3: `perr_n` is 0 in the same cycle whenever one or more enabled lanes fail the check, and 1 otherwise. It is a combinational function of the current inputs.
- R4: A lane whose bit in `lane_en` is 0 has no effect on `perr_n`. When `lane_en` is 4'b0000, `perr_n` is 1.
- R5: While `mbx_rd` = 1 and `regen_en` = 1, `perr_n` is 1 whatever the levels on `bus_in`.
- R6: While `mbx_rd` = 1 and `regen_en` = 0, the normal check of R3 and R4 applies.
- R7: `store_word` equals `bus_in` on all 36 bits, whatever the value of `regen_en`.
- R8: On a rising clock edge with `rd_load` = 1 and `regen_en` = 0, `out_word` takes `rd_word` unchanged.
- R9: On a rising clock edge with `rd_load` = 1 and `regen_en` = 1, each lane of `out_word` keeps the eight data bits of `rd_word`. Its parity bit is replaced so that the lane satisfies R2 under `odd_mode` as sampled on that same edge.
- R10: On a rising edge with `rd_load` = 0, `out_word` holds its value.
- R11: While `rst_n` is low, `out_word` is all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Read-side clock |
| rst_n | input | 1 | Active-low reset of the output register |
| bus_in | input | 36 | Word arriving at the port, to be checked and stored |
| odd_mode | input | 1 | 1 selects odd parity, 0 selects even parity |
| regen_en | input | 1 | Enables parity regeneration on reads |
| lane_en | input | 4 | Lanes in use under the current bus size, bit k for lane k |
| mbx_rd | input | 1 | A mailbox read is under way on this port |
| rd_word | input | 36 | Word read from storage |
| rd_load | input | 1 | Load `rd_word` into the output register this edge |
| perr_n | output | 1 | Active-low parity error flag |
| store_word | output | 36 | Word passed to storage, all bits unchanged |
| out_word | output | 36 | Registered read word |

## Verification
The bench places a single failing byte in each lane in turn. A design with the lane boundaries misplaced would flag the wrong lane, or miss the fault, once the mask hides that lane. It runs the same data under both parity senses and with the mask cleared; an inverted sense or an ignored mask shows up as a flag that disagrees with the bench model. It drives mailbox reads with regeneration on and with it off, which catches a design that suppresses the flag too often or never. It also changes `odd_mode` in the very cycle of a regenerating load, so a design that used a delayed mode, or left the stored top bit in place, would produce a wrong parity bit in `out_word`.

// File: rtl/parity_lane_pkg.sv
package parity_lane_pkg;
    localparam int LANES_DEFAULT     = 4;
    localparam int LANE_BITS_DEFAULT = 9;

    typedef enum logic {
        PAR_EVEN = 1'b0,
        PAR_ODD  = 1'b1
    } par_mode_e;
endpackage

// File: rtl/lane_checker.sv
module lane_checker #(
    parameter int N_LANES = parity_lane_pkg::LANES_DEFAULT,
    parameter int LANE_W  = parity_lane_pkg::LANE_BITS_DEFAULT,
    localparam int WORD_W = N_LANES * LANE_W
) (
    input  logic [WORD_W-1:0]  word,
    input  logic [N_LANES-1:0] lane_en,
    input  logic               odd_mode,
    input  logic               hold_off,
    output logic               err_n
);
    logic [N_LANES-1:0] lane_bad;

    // One parity tree per lane: a fault is a lane whose XOR disagrees with the mode
    for (genvar k = 0; k < N_LANES; k++) begin : g_tree
        assign lane_bad[k] = lane_en[k] & ((^word[k*LANE_W +: LANE_W]) ^ odd_mode);
    end

    assign err_n = hold_off | ~(|lane_bad);
endmodule

// File: rtl/lane_regen.sv
module lane_regen #(
    parameter int N_LANES = parity_lane_pkg::LANES_DEFAULT,
    parameter int LANE_W  = parity_lane_pkg::LANE_BITS_DEFAULT,
    localparam int WORD_W = N_LANES * LANE_W,
    localparam int DATA_W = LANE_W - 1
) (
    input  logic [WORD_W-1:0] word_in,
    input  logic              odd_mode,
    input  logic              regen_en,
    output logic [WORD_W-1:0] word_out
);
    for (genvar k = 0; k < N_LANES; k++) begin : g_lane
        logic [DATA_W-1:0] payload;
        logic              fresh_par;
        assign payload   = word_in[k*LANE_W +: DATA_W];
        assign fresh_par = (^payload) ^ odd_mode;
        assign word_out[k*LANE_W +: DATA_W] = payload;
        assign word_out[k*LANE_W + DATA_W]  = regen_en ? fresh_par
                                                       : word_in[k*LANE_W + DATA_W];
    end
endmodule

// File: rtl/parity_lane_guard.sv
module parity_lane_guard #(
    parameter int N_LANES = parity_lane_pkg::LANES_DEFAULT,
    parameter int LANE_W  = parity_lane_pkg::LANE_BITS_DEFAULT,
    localparam int WORD_W = N_LANES * LANE_W,
    localparam int DATA_W = LANE_W - 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [WORD_W-1:0]  bus_in,
    input  logic               odd_mode,
    input  logic               regen_en,
    input  logic [N_LANES-1:0] lane_en,
    input  logic               mbx_rd,
    input  logic [WORD_W-1:0]  rd_word,
    input  logic               rd_load,
    output logic               perr_n,
    output logic [WORD_W-1:0]  store_word,
    output logic [WORD_W-1:0]  out_word
);
    import parity_lane_pkg::*;

    typedef struct packed {
        logic [WORD_W-1:0] word;
    } out_state_t;

    out_state_t state_d, state_q;
    logic [WORD_W-1:0] regen_word;
    logic              trees_busy;

    // Trees are lent to regeneration during a mailbox read with regen on
    assign trees_busy = mbx_rd & regen_en;

    lane_checker #(.N_LANES(N_LANES), .LANE_W(LANE_W)) u_check (
        .word     (bus_in),
        .lane_en  (lane_en),
        .odd_mode (odd_mode),
        .hold_off (trees_busy),
        .err_n    (perr_n)
    );

    lane_regen #(.N_LANES(N_LANES), .LANE_W(LANE_W)) u_regen (
        .word_in  (rd_word),
        .odd_mode (odd_mode),
        .regen_en (regen_en),
        .word_out (regen_word)
    );

    assign store_word = bus_in;

    always_comb begin
        state_d = state_q;
        if (rd_load) begin
            state_d.word = regen_word;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign out_word = state_q.word;

    // ---------------- assertions ----------------
    always_comb begin
        if (rst_n && mbx_rd && regen_en) begin
            p_mbx_quiet_r5: assert (perr_n == 1'b1);
        end
        if (rst_n && lane_en == '0) begin
            p_no_lanes_r4: assert (perr_n == 1'b1);
        end
    end

    p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_load |=> $stable(out_word));

    p_raw_load_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_load && !regen_en) |=> out_word == $past(rd_word));

    for (genvar k = 0; k < N_LANES; k++) begin : g_chk
        p_regen_par_r9: assert property (@(posedge clk) disable iff (!rst_n)
            (rd_load && regen_en) |=>
            ((^out_word[k*LANE_W +: LANE_W]) == ($past(odd_mode) == PAR_ODD)));
        p_regen_data_r9: assert property (@(posedge clk) disable iff (!rst_n)
            (rd_load && regen_en) |=>
            out_word[k*LANE_W +: DATA_W] == $past(rd_word[k*LANE_W +: DATA_W]));
    end
endmodule

// File: tb/tb_parity_lane_guard.sv
module tb_parity_lane_guard;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [35:0] bus_in = '0;
    logic        odd_mode = 1'b0;
    logic        regen_en = 1'b0;
    logic [3:0]  lane_en = '0;
    logic        mbx_rd = 1'b0;
    logic [35:0] rd_word = '0;
    logic        rd_load = 1'b0;
    logic        perr_n;
    logic [35:0] store_word;
    logic [35:0] out_word;

    int errors = 0;
    int checks = 0;
    bit done = 0;
    logic [35:0] exp_out = '0;

    always #2.5 clk = ~clk;

    parity_lane_guard dut (
        .clk(clk), .rst_n(rst_n), .bus_in(bus_in), .odd_mode(odd_mode),
        .regen_en(regen_en), .lane_en(lane_en), .mbx_rd(mbx_rd),
        .rd_word(rd_word), .rd_load(rd_load), .perr_n(perr_n),
        .store_word(store_word), .out_word(out_word)
    );

    function automatic logic model_flag(logic [35:0] w, logic [3:0] en,
                                        logic odd, logic regen, logic mbx);
        int ones;
        if (mbx && regen) return 1'b1;
        for (int k = 0; k < 4; k++) begin
            if (en[k]) begin
                ones = 0;
                for (int b = 0; b < 9; b++) ones += int'(w[9*k+b]);
                if ((ones % 2 == 1) != odd) return 1'b0;
            end
        end
        return 1'b1;
    endfunction

    function automatic logic [35:0] model_load(logic [35:0] w, logic odd, logic regen);
        logic [35:0] r;
        int ones;
        r = w;
        if (regen) begin
            for (int k = 0; k < 4; k++) begin
                ones = 0;
                for (int b = 0; b < 8; b++) ones += int'(w[9*k+b]);
                // top bit chosen so the whole lane has the requested ones count
                r[9*k+8] = ((ones % 2) == 1) ? ~odd : odd;
            end
        end
        return r;
    endfunction

    task automatic chk(string req, logic [35:0] act, logic [35:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // drive at negedge, check combinational outputs 1 ns later
    task automatic drive(logic [35:0] b, logic odd, logic rg, logic [3:0] en,
                         logic mb, logic [35:0] rw, logic ld, string req);
        @(negedge clk);
        chk("R8/R9/R10 out_word", out_word, exp_out);
        bus_in = b; odd_mode = odd; regen_en = rg; lane_en = en;
        mbx_rd = mb; rd_word = rw; rd_load = ld;
        #1;
        chk({req, " perr_n"}, {35'd0, perr_n}, {35'd0, model_flag(b, en, odd, rg, mb)});
        chk("R7 store_word", store_word, b);
        if (ld) exp_out = model_load(rw, odd, rg);
    endtask

    function automatic logic [35:0] good_word(logic odd, logic [35:0] seed);
        return model_load(seed, odd, 1'b1);
    endfunction

    initial begin
        #(200000 * 5);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [35:0] w;
        void'($urandom(32'd4242));
        #7;
        chk("R11 reset out_word", out_word, '0);
        @(negedge clk);
        rst_n = 1'b1;

        // R1 R3: a single faulty lane under each mode
        for (int k = 0; k < 4; k++) begin
            for (int m = 0; m < 2; m++) begin
                w = good_word(m[0], {$urandom(), $urandom()});
                drive(w, m[0], 1'b0, 4'hF, 1'b0, '0, 1'b0, "R2 clean lanes");
                w[9*k + ($urandom() % 9)] ^= 1'b1;
                drive(w, m[0], 1'b0, 4'hF, 1'b0, '0, 1'b0, "R1 R3 single lane fault");
                drive(w, m[0], 1'b0, ~(4'b1 << k), 1'b0, '0, 1'b0, "R4 fault masked");
            end
        end
        // R4: no lanes in use
        drive(36'h0_0000_0001, 1'b1, 1'b0, 4'h0, 1'b0, '0, 1'b0, "R4 empty mask");
        // R5 / R6 with all-zero bus under odd mode (every lane fails)
        drive('0, 1'b1, 1'b1, 4'hF, 1'b1, '0, 1'b0, "R5 mailbox regen hold");
        drive('0, 1'b1, 1'b0, 4'hF, 1'b1, '0, 1'b0, "R6 mailbox no regen");
        drive('0, 1'b1, 1'b1, 4'hF, 1'b0, '0, 1'b0, "R3 regen no mailbox");
        // R8 R9: loads, mode toggled on the load edge
        drive('0, 1'b0, 1'b0, 4'hF, 1'b0, 36'hF_FFFF_FFFF, 1'b1, "R8 raw load");
        drive('0, 1'b1, 1'b1, 4'hF, 1'b0, 36'h1_2345_6789, 1'b1, "R9 regen odd");
        drive('0, 1'b0, 1'b1, 4'hF, 1'b0, 36'h1_2345_6789, 1'b1, "R9 regen even");
        drive('0, 1'b1, 1'b0, 4'hF, 1'b0, 36'hA_AAAA_AAAA, 1'b0, "R10 hold");

        // constrained random mix
        for (int i = 0; i < 400; i++) begin
            w = {$urandom(), $urandom()};
            if ($urandom() % 2) w = good_word($urandom() % 2 == 1, w);
            drive(w, 1'($urandom()), 1'($urandom()), 4'($urandom()),
                  ($urandom() % 4) == 0, {$urandom(), $urandom()},
                  1'($urandom()), "R3 random");
        end
        @(negedge clk);
        chk("R8/R9/R10 out_word final", out_word, exp_out);

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule